// File: doc/BRIEF.md
# Differential ADC Pair Result Encoder

This block sits behind a fixed pair of 16-bit converter channels, A and B, that sample at the same instant. It produces one 16-bit word that encodes the master channel's code minus the other channel's code. A select bit chooses which channel is master. Three output encodings are available: a signed two's-complement word at half scale, an offset-binary word at half scale, and a full-scale unsigned word in which negative differences are forced to zero.

A conversion starts only from a hardware trigger. Both channels must have differential mode enabled, and channel A must name its fixed partner. When these hold, the block sends a one-cycle start strobe to both channels and waits for the pair of samples. Samples arrive together with a sample-valid strobe. The encoded word is registered with a one-cycle valid pulse.

Two sticky flags report misuse:
- The configuration flag covers differential mode enabled on one channel only, and a request for a partner that is not the fixed one.
- The trigger flag covers a software trigger that arrives while differential mode is active.

Both flags hold until the clear input is raised.

Top module: `diffpair_encoder`

## Requirements
- R1: The difference is master code minus slave code, taken as a 17-bit signed value. With `master_sel`=0, channel A is master. With `master_sel`=1, channel B is master, which inverts the sign.
- R2: With `full_res`=0 and `pos_mode`=0, the result is the difference shifted right arithmetically by one, as two's complement (-32768..+32767). A zero difference gives 0x0000.
- R3: With `full_res`=0 and `pos_mode`=1, the result is the shifted difference plus 32768, as unsigned offset code. A zero difference gives 0x8000.
- R4: With `full_res`=1, the result is the unshifted difference, and a negative difference is clamped to 0x0000. `pos_mode` has no effect in this mode.
- R5: `conv_start` is high for exactly the cycle after a cycle in which `hw_trig` was high and the configuration was valid. A valid configuration means both enables are set and `partner_req` equals `PARTNER_ID`.
- R6: `sw_trig` never raises `conv_start`. When it arrives while differential mode is active, it sets `trig_err`.
- R7: An enable on exactly one channel sets `cfg_err`. In that state, no conversion starts and no result is produced.
- R8: With any enable set, a `partner_req` other than `PARTNER_ID` sets `cfg_err`, and no conversion starts.
- R9: If a start is pending, `sample_valid` loads `result` and raises `result_valid` for exactly one cycle, on the following cycle. A `sample_valid` with no pending start is ignored: `result` stays unchanged and `result_valid` stays low.
- R10: `cfg_err` and `trig_err` stay set until `err_clr` is high. A new error condition in the clearing cycle wins over the clear.
- R11: A synchronous active-high `rst` clears `result`, `result_valid`, `conv_start`, the pending start and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 0: channel A master, 1: channel B master |
| diff_en_a | input | 1 | Differential enable, channel A |
| diff_en_b | input | 1 | Differential enable, channel B |
| partner_req | input | PID_W | Partner id requested for channel A |
| full_res | input | 1 | Full-scale clamped encoding |
| pos_mode | input | 1 | Offset-binary encoding when full_res is 0 |
| hw_trig | input | 1 | Shared hardware trigger |
| sw_trig | input | 1 | Software trigger (illegal in differential mode) |
| sample_a | input | DATA_W | Channel A code |
| sample_b | input | DATA_W | Channel B code |
| sample_valid | input | 1 | Both samples present |
| err_clr | input | 1 | Clears sticky flags |
| conv_start | output | 1 | Start strobe to both channels |
| result | output | DATA_W | Encoded differential word |
| result_valid | output | 1 | One-cycle result pulse |
| cfg_err | output | 1 | Sticky configuration error |
| trig_err | output | 1 | Sticky illegal-trigger flag |

## Verification
The embedded properties check the cycle-level behaviour of the control path on every cycle:
- a start strobe always follows a hardware trigger with both enables set;
- a valid pulse always follows a sample strobe and never lasts two cycles;
- the result word holds still between pulses;
- both flags stay set until cleared.

Only the bench's scenarios can show the arithmetic. It compares each encoding against an independent model, under randomized codes, random master choice and random mode bits. Directed cases cover the boundaries: zero difference, full-scale extremes, swapped polarity, rejected configurations and ignored triggers.

// File: rtl/diffpair_pkg.sv
package diffpair_pkg;

    typedef enum logic [1:0] {
        ENC_SIGNED = 2'd0,
        ENC_OFFSET = 2'd1,
        ENC_FULL   = 2'd2
    } enc_mode_e;

    function automatic enc_mode_e pick_mode(input logic full_res, input logic pos_mode);
        if (full_res)      return ENC_FULL;
        else if (pos_mode) return ENC_OFFSET;
        else               return ENC_SIGNED;
    endfunction

endpackage

// File: rtl/dp_cfg_check.sv
module dp_cfg_check #(
    parameter int unsigned PID_W      = 2,
    parameter int unsigned PARTNER_ID = 1
) (
    input  logic             en_a,
    input  logic             en_b,
    input  logic [PID_W-1:0] partner_req,
    output logic             diff_active,
    output logic             cfg_bad
);
    localparam logic [PID_W-1:0] PID = PID_W'(PARTNER_ID);

    logic pair_ok;

    always_comb begin
        pair_ok     = (partner_req == PID);
        diff_active = en_a && en_b && pair_ok;
        cfg_bad     = (en_a ^ en_b) || ((en_a || en_b) && !pair_ok);
    end

    // R7 R8: an active pair and a configuration fault exclude each other
    always_comb begin
        cfg_excl_chk: assert (!(diff_active && cfg_bad));
    end
endmodule

// File: rtl/dp_code_map.sv
module dp_code_map
    import diffpair_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] smp_a,
    input  logic [DATA_W-1:0] smp_b,
    input  logic              b_is_master,
    input  enc_mode_e         mode,
    output logic [DATA_W-1:0] code
);
    localparam int unsigned DW = DATA_W + 1;
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] mst, slv;
    logic signed [DW-1:0] delta, half;

    always_comb begin
        mst   = b_is_master ? smp_b : smp_a;
        slv   = b_is_master ? smp_a : smp_b;
        delta = $signed({1'b0, mst}) - $signed({1'b0, slv});
        half  = delta >>> 1;
        unique case (mode)
            ENC_FULL:   code = delta[DW-1] ? '0 : delta[DATA_W-1:0];
            ENC_OFFSET: code = half[DATA_W-1:0] + MID;
            default:    code = half[DATA_W-1:0];
        endcase
    end

    // R4: a clamped output is zero whenever the slave is not below the master
    always_comb begin
        if (mode == ENC_FULL && slv >= mst) begin
            full_clamp_chk: assert (code == '0);
        end
    end
endmodule

// File: rtl/diffpair_encoder.sv
module diffpair_encoder
    import diffpair_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned PID_W      = 2,
    parameter int unsigned PARTNER_ID = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_sel,
    input  logic              diff_en_a,
    input  logic              diff_en_b,
    input  logic [PID_W-1:0]  partner_req,
    input  logic              full_res,
    input  logic              pos_mode,
    input  logic              hw_trig,
    input  logic              sw_trig,
    input  logic [DATA_W-1:0] sample_a,
    input  logic [DATA_W-1:0] sample_b,
    input  logic              sample_valid,
    input  logic              err_clr,
    output logic              conv_start,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              cfg_err,
    output logic              trig_err
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              result_valid;
        logic              conv_start;
        logic              pending;
        logic              cfg_err;
        logic              trig_err;
    } state_t;

    state_t st_d, st_q;
    logic diff_active, cfg_bad;
    logic [DATA_W-1:0] code;

    dp_cfg_check #(.PID_W(PID_W), .PARTNER_ID(PARTNER_ID)) u_cfg (
        .en_a        (diff_en_a),
        .en_b        (diff_en_b),
        .partner_req (partner_req),
        .diff_active (diff_active),
        .cfg_bad     (cfg_bad)
    );

    dp_code_map #(.DATA_W(DATA_W)) u_map (
        .smp_a       (sample_a),
        .smp_b       (sample_b),
        .b_is_master (master_sel),
        .mode        (pick_mode(full_res, pos_mode)),
        .code        (code)
    );

    always_comb begin
        logic start_d, accept_d;
        st_d     = st_q;
        start_d  = hw_trig && diff_active;
        accept_d = sample_valid && st_q.pending && diff_active;

        st_d.conv_start   = start_d;
        st_d.result_valid = accept_d;
        if (accept_d) st_d.result = code;
        st_d.pending  = start_d || (st_q.pending && !accept_d && diff_active);
        st_d.cfg_err  = (st_q.cfg_err && !err_clr) || cfg_bad;
        st_d.trig_err = (st_q.trig_err && !err_clr) || (sw_trig && diff_active);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign conv_start   = st_q.conv_start;
    assign result       = st_q.result;
    assign result_valid = st_q.result_valid;
    assign cfg_err      = st_q.cfg_err;
    assign trig_err     = st_q.trig_err;

    // R5 R6: a start strobe follows a hardware trigger with both enables set
    start_hw_only_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> ($past(hw_trig) && $past(diff_en_a) && $past(diff_en_b)));

    // R9: a valid pulse follows a sample strobe and lasts one cycle
    valid_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> ($past(sample_valid) && !$past(result_valid)));

    // R9: the result word holds between valid pulses
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));

    // R10: the configuration flag holds until cleared
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !err_clr) |=> cfg_err);

    // R10: the trigger flag holds until cleared
    trig_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_err && !err_clr) |=> trig_err);
endmodule

// File: tb/diffpair_encoder_tb.sv
module diffpair_encoder_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_sel = 0, diff_en_a = 0, diff_en_b = 0;
    logic [1:0] partner_req = 2'd1;
    logic full_res = 0, pos_mode = 0, hw_trig = 0, sw_trig = 0;
    logic [15:0] sample_a = 0, sample_b = 0;
    logic sample_valid = 0, err_clr = 0;
    logic conv_start, result_valid, cfg_err, trig_err;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    diffpair_encoder u_dut (
        .clk(clk), .rst(rst), .master_sel(master_sel),
        .diff_en_a(diff_en_a), .diff_en_b(diff_en_b), .partner_req(partner_req),
        .full_res(full_res), .pos_mode(pos_mode), .hw_trig(hw_trig), .sw_trig(sw_trig),
        .sample_a(sample_a), .sample_b(sample_b), .sample_valid(sample_valid),
        .err_clr(err_clr), .conv_start(conv_start), .result(result),
        .result_valid(result_valid), .cfg_err(cfg_err), .trig_err(trig_err)
    );

    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic bm, input logic fr, input logic pm);
        int d, h;
        d = bm ? (int'(b) - int'(a)) : (int'(a) - int'(b));
        if (fr) return (d < 0) ? 16'h0000 : d[15:0];
        h = d >>> 1;
        if (pm) return 16'(h + 32768);
        return h[15:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one hardware-triggered conversion; checks strobe and result
    task automatic convert(input string req, input logic [15:0] a, input logic [15:0] b,
                           input logic bm, input logic fr, input logic pm);
        @(negedge clk);
        master_sel = bm; full_res = fr; pos_mode = pm; hw_trig = 1;
        @(posedge clk); #1;
        check("R5 start", {31'd0, conv_start}, 32'd1);
        @(negedge clk);
        hw_trig = 0; sample_a = a; sample_b = b; sample_valid = 1;
        @(posedge clk); #1;
        check(req, {15'd0, result_valid, result}, {15'd0, 1'b1, model(a, b, bm, fr, pm)});
        @(negedge clk);
        sample_valid = 0;
        @(posedge clk); #1;
        check("R9 pulse", {31'd0, result_valid}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] hold;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check("R11 reset", {11'd0, conv_start, result_valid, cfg_err, trig_err, result},
              32'd0);
        @(negedge clk); rst = 0; diff_en_a = 1; diff_en_b = 1;

        // R2 signed, zero and polarity
        convert("R2 zero", 16'd30000, 16'd30000, 0, 0, 0);
        convert("R2 pos", 16'd20000, 16'd10000, 0, 0, 0);
        convert("R2 neg", 16'd10000, 16'd20000, 0, 0, 0);
        convert("R2 min", 16'd0, 16'hffff, 0, 0, 0);
        // R1 swap master
        convert("R1 swap", 16'd20000, 16'd10000, 1, 0, 0);
        // R3 offset
        convert("R3 zero", 16'd5, 16'd5, 0, 0, 1);
        convert("R3 max", 16'hffff, 16'd0, 0, 0, 1);
        // R4 full, clamp, pos_mode ignored
        convert("R4 pos", 16'd19860, 16'd9930, 0, 1, 0);
        convert("R4 clamp", 16'd100, 16'd9000, 0, 1, 1);
        convert("R4 max", 16'hffff, 16'd0, 0, 1, 1);

        // R9 sample with no pending start is ignored
        hold = result;
        @(negedge clk); sample_a = 16'd1; sample_b = 16'd999; sample_valid = 1;
        @(posedge clk); #1;
        check("R9 ignored", {15'd0, result_valid, result}, {15'd0, 1'b0, hold});
        @(negedge clk); sample_valid = 0;

        // R6 software trigger: no start, sets trig_err
        @(negedge clk); sw_trig = 1;
        @(posedge clk); #1;
        check("R6 no start", {30'd0, conv_start, trig_err}, 32'd1);
        @(negedge clk); sw_trig = 0;
        @(posedge clk); #1;
        check("R10 trig hold", {31'd0, trig_err}, 32'd1);
        @(negedge clk); err_clr = 1;
        @(posedge clk); #1;
        check("R10 trig clr", {31'd0, trig_err}, 32'd0);
        @(negedge clk); err_clr = 0;

        // R7 one channel only
        @(negedge clk); diff_en_b = 0; hw_trig = 1;
        @(posedge clk); #1;
        check("R7 cfg", {30'd0, conv_start, cfg_err}, 32'd1);
        @(negedge clk); hw_trig = 0; sample_valid = 1;
        @(posedge clk); #1;
        check("R7 no result", {31'd0, result_valid}, 32'd0);
        @(negedge clk); sample_valid = 0; diff_en_b = 1; err_clr = 1;
        @(posedge clk); #1;
        check("R10 cfg clr", {31'd0, cfg_err}, 32'd0);
        @(negedge clk); err_clr = 0;

        // R8 wrong partner
        @(negedge clk); partner_req = 2'd3; hw_trig = 1;
        @(posedge clk); #1;
        check("R8 partner", {30'd0, conv_start, cfg_err}, 32'd1);
        @(negedge clk); hw_trig = 0; partner_req = 2'd1;
        @(posedge clk); #1;
        check("R10 cfg hold", {31'd0, cfg_err}, 32'd1);
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;

        // random mix, R1 to R4
        for (int i = 0; i < 300; i++) begin
            logic [2:0] m;
            m = 3'($urandom);
            convert("R1-mix random", 16'($urandom), 16'($urandom), m[0], m[1], m[2]);
        end

        // R11 reset mid-run
        @(negedge clk); rst = 1; sw_trig = 1;
        @(posedge clk); #1;
        check("R11 reset2", {14'd0, conv_start, result_valid, trig_err, result}, 32'd0);
        @(negedge clk); rst = 0; sw_trig = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule